// File: doc/BRIEF.md
# Vector loop issue controller

This block sequences instruction issue for a small in-order core with a prefixed vector-loop extension. It requests an instruction word and holds it for the decoder. When decode completes, it starts the execute unit once, or runs execute several times over a vector length (VL) of element steps, or drops the instruction without executing it. The PC register and the loop state register (VL and the current element step) are kept here. They advance when an instruction completes.

A prefixed instruction is eight bytes long and an unprefixed one is four. A loop runs while the decoded instruction has a vector destination. Between two loop iterations the controller passes through a separate re-decode state, so the decoder can produce the register numbers for the new step. If the execute unit reports that it changed the PC or the loop state itself, the controller returns to fetch and leaves both registers as they are.

A core-stop input holds the controller at the start of the next instruction. While the core is held there, a debug port can load the PC and the loop state.

Top module: `vloop_issue_ctrl`

## Requirements
- R1: After decode, a prefixed instruction (dec_prefixed_i=1) with VL zero starts no execute. The PC advances by 8, the step becomes 0 and the controller requests the next fetch. No opcode is examined.
- R2: When an instruction completes normally, the PC advances by 8 if it was prefixed and by 4 if it was not.
- R3: If exec_pc_chg_i or exec_st_chg_i is seen at any time between the execute handshake and the end of busy, the controller returns to fetch with PC and step unchanged. A flag that stays high after busy ends does not affect the next instruction.
- R4: After an execute pass ends, the instruction completes if it is unprefixed, has no vector destination (dec_vdest_i=0), or is on its last step (step+1 >= VL). The step then returns to 0.
- R5: In every other case the step increments and dec_req_o is raised again for a re-decode before the next exec_start_o. A vector instruction starting at step 0 therefore executes exactly VL times. exec_start_o stays high until exec_busy_i is seen.
- R6: dec_insn_o changes only when a fetch is accepted (fetch_req_o and fetch_ack_i both high). It stays constant for the whole vector loop.
- R7: insn_done_o is high for exactly one cycle each time an instruction finishes, is skipped or is redirected. It does not pulse between loop iterations.
- R8: While core_stop_i is high, fetch_req_o is low.
- R9: While stopped in the fetch state, the debug strobes load the PC and the loop state. The next fetch address equals the loaded PC.
- R10: Two back-to-back vector instructions each begin their first decode at step 0.
- R11: A debug VL above 64 is stored as 64.
- R12: After reset, PC, VL and step are 0 and, with core_stop_i low, fetch_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_stop_i | input | 1 | Hold the core at instruction start |
| dbg_pc_we_i | input | 1 | Debug PC write strobe (honoured while stopped in fetch) |
| dbg_pc_i | input | PC_W | Debug PC value |
| dbg_st_we_i | input | 1 | Debug loop-state write strobe |
| dbg_vl_i | input | STEP_W | Debug VL value (clamped to VL_MAX) |
| dbg_step_i | input | STEP_W | Debug step value |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | PC_W | Fetch address (current PC) |
| fetch_ack_i | input | 1 | Fetch response valid |
| fetch_insn_i | input | INSN_W | Fetched instruction word |
| dec_req_o | output | 1 | Decode or re-decode request |
| dec_insn_o | output | INSN_W | Held instruction word for the decoder |
| dec_valid_i | input | 1 | Decoder result valid strobe |
| dec_prefixed_i | input | 1 | Instruction carries the vector prefix |
| dec_vdest_i | input | 1 | Instruction has a vector destination |
| exec_start_o | output | 1 | Execute start, held until busy is seen |
| exec_busy_i | input | 1 | Execute unit busy |
| exec_pc_chg_i | input | 1 | Execute changed the PC |
| exec_st_chg_i | input | 1 | Execute changed the loop state |
| pc_o | output | PC_W | PC register |
| vl_o | output | STEP_W | Vector length register |
| step_o | output | STEP_W | Current element step |
| insn_done_o | output | 1 | Instruction completion pulse |

## Verification
The hardest cases to reach from the ports are a redirect in the middle of a loop and a redirect flag that stays high after busy ends. In both, the step is nonzero when the next instruction begins. The stimulus gets there with random redirect flags on random vector instructions, and with a directed case that preloads a nonzero step through the debug port and then redirects. Random handshake delays separate the fetch, decode and execute phases, and the flags are kept high after busy to catch stale state.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_XSTART = 3'd2,
    ST_XWAIT  = 3'd3,
    ST_REDEC  = 3'd4
  } ctl_state_e;

  localparam int PFX_BYTES   = 8;
  localparam int PLAIN_BYTES = 4;
endpackage

// File: rtl/vloop_seq.sv
module vloop_seq
  import vloop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_stop_i,
  input  logic       fetch_ack_i,
  input  logic       dec_valid_i,
  input  logic       dec_prefixed_i,
  input  logic       vl_zero_i,
  input  logic       exec_busy_i,
  input  logic       chg_i,
  input  logic       last_i,
  output ctl_state_e state_o,
  output logic       fetch_req_o,
  output logic       fetch_fire_o,
  output logic       dec_req_o,
  output logic       dec_cap_o,
  output logic       skip_o,
  output logic       exec_start_o,
  output logic       xwait_o,
  output logic       finish_o,
  output logic       loop_step_o,
  output logic       done_o
);
  ctl_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       xend, redirect;

  always_comb begin
    fetch_req_o  = (state_q == ST_FETCH) && !core_stop_i;
    fetch_fire_o = fetch_req_o && fetch_ack_i;
    dec_req_o    = (state_q == ST_DECODE) || (state_q == ST_REDEC);
    dec_cap_o    = (state_q == ST_DECODE) && dec_valid_i;
    skip_o       = dec_cap_o && dec_prefixed_i && vl_zero_i;
    exec_start_o = (state_q == ST_XSTART);
    xwait_o      = (state_q == ST_XWAIT);
    xend         = xwait_o && !exec_busy_i;
    redirect     = xend && chg_i;
    finish_o     = xend && !chg_i && last_i;
    loop_step_o  = xend && !chg_i && !last_i;
    done_d       = skip_o || redirect || finish_o;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  if (fetch_fire_o) state_d = ST_DECODE;
      ST_DECODE: if (dec_valid_i)  state_d = skip_o ? ST_FETCH : ST_XSTART;
      ST_XSTART: if (exec_busy_i)  state_d = ST_XWAIT;
      ST_XWAIT:  if (!exec_busy_i) state_d = (redirect || finish_o) ? ST_FETCH : ST_REDEC;
      ST_REDEC:  if (dec_valid_i)  state_d = ST_XSTART;
      default:                     state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;
endmodule

// File: rtl/vloop_hold.sv
module vloop_hold #(
  parameter int INSN_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_fire_i,
  input  logic [INSN_W-1:0] fetch_insn_i,
  input  logic              dec_cap_i,
  input  logic              dec_prefixed_i,
  input  logic              dec_vdest_i,
  input  logic              xwait_i,
  input  logic              pc_chg_i,
  input  logic              st_chg_i,
  output logic [INSN_W-1:0] insn_o,
  output logic              pfx_o,
  output logic              vdest_o,
  output logic              chg_o
);
  logic [INSN_W-1:0] insn_q;
  logic              pfx_q, vdest_q, sticky_q, sticky_d, sticky_en;
  logic              live_chg;

  always_comb begin
    live_chg  = xwait_i && (pc_chg_i || st_chg_i);
    sticky_en = fetch_fire_i || live_chg;
    sticky_d  = fetch_fire_i ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      insn_q   <= '0;
      pfx_q    <= 1'b0;
      vdest_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (fetch_fire_i) insn_q <= fetch_insn_i;
      if (dec_cap_i) begin
        pfx_q   <= dec_prefixed_i;
        vdest_q <= dec_vdest_i;
      end
      if (sticky_en) sticky_q <= sticky_d;
    end
  end

  assign insn_o  = insn_q;
  assign pfx_o   = pfx_q;
  assign vdest_o = vdest_q;
  assign chg_o   = sticky_q || live_chg;
endmodule

// File: rtl/vloop_regs.sv
module vloop_regs
  import vloop_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int VL_MAX = 64,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en_i,
  input  logic              dbg_pc_we_i,
  input  logic [PC_W-1:0]   dbg_pc_i,
  input  logic              dbg_st_we_i,
  input  logic [STEP_W-1:0] dbg_vl_i,
  input  logic [STEP_W-1:0] dbg_step_i,
  input  logic              skip_i,
  input  logic              finish_i,
  input  logic              loop_step_i,
  input  logic              pfx_i,
  input  logic              vdest_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [STEP_W-1:0] vl_o,
  output logic [STEP_W-1:0] step_o,
  output logic              vl_zero_o,
  output logic              last_o
);
  localparam logic [STEP_W-1:0] VL_CAP = STEP_W'(VL_MAX);
  localparam logic [PC_W-1:0]   ADV_L  = PC_W'(PFX_BYTES);
  localparam logic [PC_W-1:0]   ADV_S  = PC_W'(PLAIN_BYTES);

  logic [PC_W-1:0]   pc_q, pc_d;
  logic [STEP_W-1:0] vl_q, vl_d, step_q, step_d;
  logic              pc_en, vl_en, step_en, adv, adv_long;
  logic [STEP_W:0]   step_nx;

  always_comb begin
    adv      = skip_i || finish_i;
    adv_long = skip_i || (finish_i && pfx_i);
    pc_en    = (dbg_en_i && dbg_pc_we_i) || adv;
    pc_d     = (dbg_en_i && dbg_pc_we_i) ? dbg_pc_i
                                         : pc_q + (adv_long ? ADV_L : ADV_S);
    vl_en    = dbg_en_i && dbg_st_we_i;
    vl_d     = (dbg_vl_i > VL_CAP) ? VL_CAP : dbg_vl_i;
    step_en  = vl_en || adv || loop_step_i;
    if (vl_en)    step_d = dbg_step_i;
    else if (adv) step_d = '0;
    else          step_d = step_q + 1'b1;
    step_nx   = {1'b0, step_q} + 1'b1;
    vl_zero_o = (vl_q == '0);
    last_o    = !pfx_i || !vdest_i || (step_nx >= {1'b0, vl_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      vl_q   <= '0;
      step_q <= '0;
    end else begin
      if (pc_en)   pc_q   <= pc_d;
      if (vl_en)   vl_q   <= vl_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign pc_o   = pc_q;
  assign vl_o   = vl_q;
  assign step_o = step_q;
endmodule

// File: rtl/vloop_issue_ctrl.sv
module vloop_issue_ctrl
  import vloop_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INSN_W = 64,
  parameter int VL_MAX = 64,
  localparam int STEP_W = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_stop_i,
  input  logic              dbg_pc_we_i,
  input  logic [PC_W-1:0]   dbg_pc_i,
  input  logic              dbg_st_we_i,
  input  logic [STEP_W-1:0] dbg_vl_i,
  input  logic [STEP_W-1:0] dbg_step_i,
  output logic              fetch_req_o,
  output logic [PC_W-1:0]   fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [INSN_W-1:0] fetch_insn_i,
  output logic              dec_req_o,
  output logic [INSN_W-1:0] dec_insn_o,
  input  logic              dec_valid_i,
  input  logic              dec_prefixed_i,
  input  logic              dec_vdest_i,
  output logic              exec_start_o,
  input  logic              exec_busy_i,
  input  logic              exec_pc_chg_i,
  input  logic              exec_st_chg_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [STEP_W-1:0] vl_o,
  output logic [STEP_W-1:0] step_o,
  output logic              insn_done_o
);
  ctl_state_e st_w;
  logic fetch_fire_w, dec_cap_w, skip_w, xwait_w, finish_w, loop_step_w;
  logic chg_w, last_w, vl_zero_w, pfx_w, vdest_w, dbg_en_w;

  assign dbg_en_w     = (st_w == ST_FETCH) && core_stop_i;
  assign fetch_addr_o = pc_o;

  vloop_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_stop_i    (core_stop_i),
    .fetch_ack_i    (fetch_ack_i),
    .dec_valid_i    (dec_valid_i),
    .dec_prefixed_i (dec_prefixed_i),
    .vl_zero_i      (vl_zero_w),
    .exec_busy_i    (exec_busy_i),
    .chg_i          (chg_w),
    .last_i         (last_w),
    .state_o        (st_w),
    .fetch_req_o    (fetch_req_o),
    .fetch_fire_o   (fetch_fire_w),
    .dec_req_o      (dec_req_o),
    .dec_cap_o      (dec_cap_w),
    .skip_o         (skip_w),
    .exec_start_o   (exec_start_o),
    .xwait_o        (xwait_w),
    .finish_o       (finish_w),
    .loop_step_o    (loop_step_w),
    .done_o         (insn_done_o)
  );

  vloop_hold #(.INSN_W(INSN_W)) u_hold (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_fire_i   (fetch_fire_w),
    .fetch_insn_i   (fetch_insn_i),
    .dec_cap_i      (dec_cap_w),
    .dec_prefixed_i (dec_prefixed_i),
    .dec_vdest_i    (dec_vdest_i),
    .xwait_i        (xwait_w),
    .pc_chg_i       (exec_pc_chg_i),
    .st_chg_i       (exec_st_chg_i),
    .insn_o         (dec_insn_o),
    .pfx_o          (pfx_w),
    .vdest_o        (vdest_w),
    .chg_o          (chg_w)
  );

  vloop_regs #(.PC_W(PC_W), .VL_MAX(VL_MAX), .STEP_W(STEP_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_en_i    (dbg_en_w),
    .dbg_pc_we_i (dbg_pc_we_i),
    .dbg_pc_i    (dbg_pc_i),
    .dbg_st_we_i (dbg_st_we_i),
    .dbg_vl_i    (dbg_vl_i),
    .dbg_step_i  (dbg_step_i),
    .skip_i      (skip_w),
    .finish_i    (finish_w),
    .loop_step_i (loop_step_w),
    .pfx_i       (pfx_w),
    .vdest_i     (vdest_w),
    .pc_o        (pc_o),
    .vl_o        (vl_o),
    .step_o      (step_o),
    .vl_zero_o   (vl_zero_w),
    .last_o      (last_w)
  );
endmodule

// File: rtl/vloop_issue_ctrl_chk.sv
module vloop_issue_ctrl_chk
  import vloop_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int INSN_W = 64,
  parameter int VL_MAX = 64,
  parameter int STEP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input ctl_state_e        st,
  input logic              core_stop_i,
  input logic              fetch_req_o,
  input logic              fetch_ack_i,
  input logic              dec_valid_i,
  input logic              dec_prefixed_i,
  input logic [INSN_W-1:0] dec_insn_o,
  input logic              exec_start_o,
  input logic              exec_busy_i,
  input logic              chg,
  input logic              last,
  input logic [PC_W-1:0]   pc_o,
  input logic [STEP_W-1:0] vl_o,
  input logic [STEP_W-1:0] step_o,
  input logic              insn_done_o
);
  a_r1_skip_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DECODE && dec_valid_i && dec_prefixed_i && vl_o == '0)
    |=> (st == ST_FETCH && !exec_start_o && pc_o == $past(pc_o) + PC_W'(8) && step_o == '0));

  a_r3_redirect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XWAIT && !exec_busy_i && chg)
    |=> (st == ST_FETCH && $stable(pc_o) && $stable(step_o)));

  a_r4_finish_clears_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XWAIT && !exec_busy_i && !chg && last)
    |=> (st == ST_FETCH && step_o == '0));

  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XWAIT && !exec_busy_i && !chg && !last)
    |=> (st == ST_REDEC && step_o == $past(step_o) + 1'b1));

  a_r6_insn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req_o && fetch_ack_i) |=> $stable(dec_insn_o));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done_o |=> !insn_done_o);

  a_r8_stop_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop_i |-> !fetch_req_o);

  a_r11_vl_cap: assert property (@(posedge clk) disable iff (!rst_n)
    vl_o <= STEP_W'(VL_MAX));
endmodule

bind vloop_issue_ctrl vloop_issue_ctrl_chk #(
  .PC_W(PC_W), .INSN_W(INSN_W), .VL_MAX(VL_MAX), .STEP_W(STEP_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .st             (st_w),
  .core_stop_i    (core_stop_i),
  .fetch_req_o    (fetch_req_o),
  .fetch_ack_i    (fetch_ack_i),
  .dec_valid_i    (dec_valid_i),
  .dec_prefixed_i (dec_prefixed_i),
  .dec_insn_o     (dec_insn_o),
  .exec_start_o   (exec_start_o),
  .exec_busy_i    (exec_busy_i),
  .chg            (chg_w),
  .last           (last_w),
  .pc_o           (pc_o),
  .vl_o           (vl_o),
  .step_o         (step_o),
  .insn_done_o    (insn_done_o)
);

// File: tb/vloop_issue_ctrl_test.sv
module vloop_issue_ctrl_test;
  localparam int PC_W = 32, INSN_W = 64, STEP_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, core_stop, dbg_pc_we, dbg_st_we;
  logic [PC_W-1:0]   dbg_pc;
  logic [STEP_W-1:0] dbg_vl, dbg_step;
  logic              fetch_req, fetch_ack;
  logic [PC_W-1:0]   fetch_addr;
  logic [INSN_W-1:0] fetch_insn, dec_insn;
  logic              dec_req, dec_valid, dec_pfx, dec_vd;
  logic              exec_start, exec_busy, pc_chg, st_chg;
  logic [PC_W-1:0]   pc;
  logic [STEP_W-1:0] vl, step;
  logic              insn_done;

  vloop_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .core_stop_i(core_stop),
    .dbg_pc_we_i(dbg_pc_we), .dbg_pc_i(dbg_pc), .dbg_st_we_i(dbg_st_we),
    .dbg_vl_i(dbg_vl), .dbg_step_i(dbg_step),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_ack_i(fetch_ack),
    .fetch_insn_i(fetch_insn), .dec_req_o(dec_req), .dec_insn_o(dec_insn),
    .dec_valid_i(dec_valid), .dec_prefixed_i(dec_pfx), .dec_vdest_i(dec_vd),
    .exec_start_o(exec_start), .exec_busy_i(exec_busy),
    .exec_pc_chg_i(pc_chg), .exec_st_chg_i(st_chg),
    .pc_o(pc), .vl_o(vl), .step_o(step), .insn_done_o(insn_done)
  );

  int checks = 0, fails = 0, done_cnt = 0;
  logic [PC_W-1:0] m_pc;
  int m_vl, m_step;

  always @(posedge clk) if (rst_n && insn_done) done_cnt++;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // expected outcome of one instruction from the requirements
  task automatic predict(input bit pfx, input bit vd, input bit redir,
                         output int execs, output logic [PC_W-1:0] e_pc, output int e_step);
    int s;
    execs = 0; e_pc = m_pc; s = m_step;
    if (pfx && m_vl == 0) begin
      e_pc = m_pc + 8; s = 0;
    end else begin
      forever begin
        execs++;
        if (redir) break;
        if (!pfx || !vd || s + 1 >= m_vl) begin
          e_pc = m_pc + (pfx ? 8 : 4); s = 0; break;
        end
        s++;
      end
    end
    e_step = s;
  endtask

  task automatic dbg_set(input bit wpc, input logic [PC_W-1:0] npc,
                         input bit wst, input int nvl, input int nstep);
    core_stop = 1'b1;
    tick();
    chk("R8 fetch_req while stopped", fetch_req, 0);
    tick();
    chk("R8 fetch_req while stopped", fetch_req, 0);
    dbg_pc_we = wpc; dbg_pc = npc;
    dbg_st_we = wst; dbg_vl = STEP_W'(nvl); dbg_step = STEP_W'(nstep);
    tick();
    dbg_pc_we = 1'b0; dbg_st_we = 1'b0;
    if (wpc) m_pc = npc;
    if (wst) begin m_vl = (nvl > 64) ? 64 : nvl; m_step = nstep; end
    chk("R9 debug pc", pc, m_pc);
    chk("R11 debug vl", vl, m_vl);
    chk("R9 debug step", step, m_step);
    core_stop = 1'b0;
    tick();
  endtask

  task automatic run_insn(input bit pfx, input bit vd, input bit cpc, input bit cst, input int dly);
    int e_execs, e_step, execs, d0;
    logic [PC_W-1:0] e_pc;
    logic [INSN_W-1:0] word;
    bit first;
    predict(pfx, vd, cpc | cst, e_execs, e_pc, e_step);
    word = {$urandom, $urandom};
    d0 = done_cnt;
    while (!fetch_req) tick();
    chk("R9 fetch address", fetch_addr, m_pc);
    fetch_ack = 1'b1; fetch_insn = word;
    pc_chg = 1'b0; st_chg = 1'b0;
    tick();
    fetch_ack = 1'b0; fetch_insn = ~word;
    execs = 0; first = 1'b1;
    forever begin
      while (!dec_req) tick();
      repeat (dly) tick();
      if (first) chk("R10 step at first decode", step, m_step);
      first = 1'b0;
      chk("R6 held insn word", dec_insn, word);
      dec_valid = 1'b1; dec_pfx = pfx; dec_vd = vd;
      tick();
      dec_valid = 1'b0; dec_pfx = $urandom; dec_vd = $urandom;
      if (!exec_start) break;
      execs++;
      repeat (dly) tick();
      chk("R5 start held until busy", exec_start, 1);
      exec_busy = 1'b1; pc_chg = cpc; st_chg = cst;
      tick();
      repeat (dly) tick();
      exec_busy = 1'b0;
      tick();
      if (!dec_req) break;
      if (execs > 80) break;
    end
    tick();
    chk("R1/R5 execute count", execs, e_execs);
    chk("R2/R3/R4 pc after insn", pc, e_pc);
    chk("R3/R4 step after insn", step, e_step);
    chk("R7 one done pulse", done_cnt - d0, 1);
    m_pc = e_pc; m_step = e_step;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; core_stop = 1'b0; dbg_pc_we = 1'b0; dbg_st_we = 1'b0;
    dbg_pc = '0; dbg_vl = '0; dbg_step = '0; fetch_ack = 1'b0; fetch_insn = '0;
    dec_valid = 1'b0; dec_pfx = 1'b0; dec_vd = 1'b0;
    exec_busy = 1'b0; pc_chg = 1'b0; st_chg = 1'b0;
    m_pc = '0; m_vl = 0; m_step = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R12 reset pc", pc, 0);
    chk("R12 reset vl", vl, 0);
    chk("R12 reset step", step, 0);
    chk("R12 fetch_req after reset", fetch_req, 1);
    chk("R12 no done after reset", insn_done, 0);

    dbg_set(1'b1, 32'h100, 1'b0, 0, 0);
    run_insn(1'b0, 1'b0, 1'b0, 1'b0, 0);  // R2 plain +4
    run_insn(1'b1, 1'b1, 1'b0, 1'b0, 1);  // R1 skip at VL 0
    dbg_set(1'b0, '0, 1'b1, 4, 0);
    run_insn(1'b1, 1'b1, 1'b0, 1'b0, 2);  // R5 four passes
    run_insn(1'b1, 1'b1, 1'b0, 1'b0, 0);  // R10 back to back
    run_insn(1'b1, 1'b0, 1'b0, 1'b0, 1);  // R4 no vector dest
    run_insn(1'b0, 1'b1, 1'b0, 1'b0, 0);  // R4 unprefixed
    dbg_set(1'b0, '0, 1'b1, 4, 2);
    run_insn(1'b1, 1'b1, 1'b1, 1'b0, 1);  // R3 pc changed, step stays 2
    run_insn(1'b1, 1'b1, 1'b0, 1'b1, 0);  // R3 state changed
    run_insn(1'b1, 1'b1, 1'b0, 1'b0, 0);  // R3 flags cleared: resumes at 2
    dbg_set(1'b0, '0, 1'b1, 100, 0);      // R11 clamp
    dbg_set(1'b0, '0, 1'b1, 64, 62);
    run_insn(1'b1, 1'b1, 1'b0, 1'b0, 0);  // R5 boundary step 62 -> 63 -> done

    for (int i = 0; i < 60; i++) begin
      if (i % 8 == 0) dbg_set(1'b0, '0, 1'b1, int'($urandom % 9), 0);
      run_insn(($urandom % 4) != 0, ($urandom % 3) != 0,
               ($urandom % 10) == 0, ($urandom % 10) == 0, int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule